// File: doc/BRIEF.md
# Watchdog Register Front End with Write Unlock

This block sits between a register bus and a two-stage watchdog counter. It holds the timing and control registers the counter uses. It decodes them into plain control lines: enable, free-run, lock, fast timebase, interrupt kind and reboot permission. It also issues single-cycle strobes for "restart the countdown" (ping) and "forget the last watchdog reset" (flag clear).

The memory-mapped side is a simple strobe port with a 4-bit offset, 32-bit write data, an access size and registered read data. The two preload registers and the control offset are guarded by a key sequence. Two key values must be written to the control offset, in order. After that, exactly one ordinary write is honoured and the guard closes again.

The configuration and lock registers have their own write strobes and read-back buses. Setting the lock bit makes the lock register itself read-only until reset. The counter reports a watchdog-caused reset through a set input. Software reads that flag at the control offset and clears it with a guarded write.

Top module: `wdog_regs`

## Requirements
- R1: After reset: reboot permission is 1; fast timebase, interrupt kind, enable, free-run and lock are all 0; both preloads are 0xFFFFF; the reset flag is 0; the guard is closed.
- R2: Writing the value 0x80 to offset 0xC opens the first guard step from any guard state. Writing 0x86 to offset 0xC during the first step arms the guard. Any other write in the first step leaves the first step in place, and 0x86 has no key effect outside the first step. Written values are taken after masking to the access size.
- R3: While the guard is armed, the next halfword or word write that is not a key write is accepted and closes the guard, whatever its offset. A write made while the guard is not armed never changes the preloads and raises no strobe.
- R4: Byte accesses (size 0) and size code 3 can only act as key writes: they are never accepted and they leave an armed guard armed. Size 1 is halfword and size 2 is word.
- R5: An accepted word write to offset 0x0 loads stage-one preload with data bits 19:0; one to offset 0x4 loads stage-two preload the same way.
- R6: An accepted halfword write to offset 0xC with bit 8 set raises `wd_ping` for exactly the one cycle after the write's clock edge.
- R7: An accepted halfword write to offset 0xC with bit 9 or bit 12 set raises `wd_flag_clr` for one cycle, in the same cycle as R6, and clears the reset flag.
- R8: `prev_rst_set` sets the reset flag; when a set and a clear land in the same cycle, the flag ends up set.
- R9: A halfword read of offset 0xC returns the reset flag in both bit 9 and bit 12. Every other read returns 0. Read data appears in the cycle after the read strobe and is 0 in all other cycles.
- R10: A configuration write sets these fields: bit 5 = 1 withdraws reboot permission, bit 2 = 1 selects the fast timebase, bits 1:0 give the interrupt kind. Read-back shows the same layout, and the register stays writable after lock.
- R11: A lock register write sets free-run from bit 2, enable from bit 1 and lock from bit 0, and read-back uses the same positions. Once lock is 1, lock register writes are ignored until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mm_wr | input | 1 | Memory-mapped write strobe |
| mm_rd | input | 1 | Memory-mapped read strobe |
| mm_addr | input | 4 | Register offset |
| mm_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| mm_wdata | input | 32 | Write data |
| mm_rdata | output | 32 | Read data, valid the cycle after mm_rd |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 16 | Configuration write value |
| cfg_rdata | output | 16 | Configuration read-back |
| lck_wr | input | 1 | Lock register write strobe |
| lck_wdata | input | 8 | Lock register write value |
| lck_rdata | output | 8 | Lock register read-back |
| prev_rst_set | input | 1 | Counter reports a watchdog-caused reset |
| wd_enable | output | 1 | Counter enable |
| wd_free_run | output | 1 | Restart stage one after final expiry |
| wd_locked | output | 1 | Lock register frozen |
| wd_fast_scale | output | 1 | Fast timebase selected |
| wd_irq_type | output | 2 | Stage-one interrupt kind |
| wd_reboot_en | output | 1 | Final expiry may reset the system |
| wd_ping | output | 1 | One-cycle restart strobe |
| wd_flag_clr | output | 1 | One-cycle reset-flag clear strobe |
| preload1 | output | 20 | Stage-one preload |
| preload2 | output | 20 | Stage-two preload |

## Verification
The hardest states to reach are the edges of the guard. Examples are an armed guard that an unrelated write uses up, a key byte re-sent while armed, and byte writes that pass through an armed guard without closing it. Plain random data seldom forms the two key values in order. The random stimulus therefore draws the key values, the ping and clear patterns and the guarded offsets with high weight, and mixes in all four size codes. Directed sequences cover each of those guard edges on purpose. They also cover a flag set that coincides with an accepted clear.

// File: rtl/wdog_regs_pkg.sv
package wdog_regs_pkg;

  typedef enum logic [1:0] {
    UL_IDLE  = 2'd0,
    UL_HALF  = 2'd1,
    UL_ARMED = 2'd2
  } unlock_t;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_t;

  typedef struct packed {
    logic       reboot_en;
    logic       fast_scale;
    logic [1:0] irq_type;
  } cfg_t;

  typedef struct packed {
    logic free_run;
    logic enable;
    logic locked;
  } lck_t;

endpackage

// File: rtl/wdog_unlock_fsm.sv
module wdog_unlock_fsm
  import wdog_regs_pkg::*;
#(
  parameter int                ADDR_W   = 4,
  parameter int                DATA_W   = 32,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 'hC,
  parameter logic [DATA_W-1:0] KEY_A    = 'h80,
  parameter logic [DATA_W-1:0] KEY_B    = 'h86
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] val,
  input  acc_size_t         size,
  output logic              accept,
  output unlock_t           state
);

  logic at_ctrl, key_a, key_b, wide;

  always_comb begin
    at_ctrl = (addr == CTRL_OFS);
    key_a   = wr && at_ctrl && (val == KEY_A);
    key_b   = wr && at_ctrl && (val == KEY_B) && (state == UL_HALF);
    wide    = (size == SZ_HALF) || (size == SZ_WORD);
    accept  = wr && !key_a && !key_b && wide && (state == UL_ARMED);
  end

  always_ff @(posedge clk) begin
    if (rst)         state <= UL_IDLE;
    else if (key_a)  state <= UL_HALF;
    else if (key_b)  state <= UL_ARMED;
    else if (accept) state <= UL_IDLE;
  end

endmodule

// File: rtl/wdog_mm_regs.sv
module wdog_mm_regs
  import wdog_regs_pkg::*;
#(
  parameter int                ADDR_W    = 4,
  parameter int                DATA_W    = 32,
  parameter int                PRE_W     = 20,
  parameter logic [ADDR_W-1:0] PRE1_OFS  = 'h0,
  parameter logic [ADDR_W-1:0] PRE2_OFS  = 'h4,
  parameter logic [ADDR_W-1:0] CTRL_OFS  = 'hC,
  parameter int                PING_BIT  = 8,
  parameter int                FLAG_BIT0 = 9,
  parameter int                FLAG_BIT1 = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] val,
  input  acc_size_t         size,
  input  logic              flag_set,
  output logic [PRE_W-1:0]  pre1,
  output logic [PRE_W-1:0]  pre2,
  output logic              ping,
  output logic              flag_clr,
  output logic [DATA_W-1:0] rdata
);

  localparam logic [PRE_W-1:0] PRE_INIT = '1;

  logic ctrl_hit, pre1_hit, pre2_hit, clr_req, flag;
  logic [DATA_W-1:0] flag_word;
  logic unused_val_bits;

  always_comb begin
    ctrl_hit = accept && (size == SZ_HALF) && (addr == CTRL_OFS);
    pre1_hit = accept && (size == SZ_WORD) && (addr == PRE1_OFS);
    pre2_hit = accept && (size == SZ_WORD) && (addr == PRE2_OFS);
    clr_req  = ctrl_hit && (val[FLAG_BIT0] || val[FLAG_BIT1]);
    flag_word = '0;
    flag_word[FLAG_BIT0] = flag;
    flag_word[FLAG_BIT1] = flag;
  end

  assign unused_val_bits = ^val;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre1     <= PRE_INIT;
      pre2     <= PRE_INIT;
      ping     <= 1'b0;
      flag_clr <= 1'b0;
      flag     <= 1'b0;
      rdata    <= '0;
    end else begin
      if (pre1_hit) pre1 <= val[PRE_W-1:0];
      if (pre2_hit) pre2 <= val[PRE_W-1:0];
      ping     <= ctrl_hit && val[PING_BIT];
      flag_clr <= clr_req;
      if (flag_set)     flag <= 1'b1;
      else if (clr_req) flag <= 1'b0;
      if (rd && (size == SZ_HALF) && (addr == CTRL_OFS)) rdata <= flag_word;
      else                                               rdata <= '0;
    end
  end

endmodule

// File: rtl/wdog_ctl_regs.sv
module wdog_ctl_regs
  import wdog_regs_pkg::*;
#(
  parameter int CFG_W        = 16,
  parameter int LCK_W        = 8,
  parameter int NOREBOOT_BIT = 5,
  parameter int FAST_BIT     = 2,
  parameter int IRQ_LSB      = 0,
  parameter int FREE_BIT     = 2,
  parameter int EN_BIT       = 1,
  parameter int LOCK_BIT     = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             lck_wr,
  input  logic [LCK_W-1:0] lck_wdata,
  output cfg_t             cfg,
  output lck_t             lck,
  output logic [CFG_W-1:0] cfg_rdata,
  output logic [LCK_W-1:0] lck_rdata
);

  localparam cfg_t CFG_INIT = '{reboot_en: 1'b1, fast_scale: 1'b0, irq_type: 2'd0};

  logic unused_cfg_bits, unused_lck_bits;
  assign unused_cfg_bits = ^cfg_wdata;
  assign unused_lck_bits = ^lck_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= CFG_INIT;
      lck <= '0;
    end else begin
      if (cfg_wr) begin
        cfg.reboot_en  <= !cfg_wdata[NOREBOOT_BIT];
        cfg.fast_scale <= cfg_wdata[FAST_BIT];
        cfg.irq_type   <= cfg_wdata[IRQ_LSB +: 2];
      end
      if (lck_wr && !lck.locked) begin
        lck.free_run <= lck_wdata[FREE_BIT];
        lck.enable   <= lck_wdata[EN_BIT];
        lck.locked   <= lck_wdata[LOCK_BIT];
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    cfg_rdata[NOREBOOT_BIT]  = !cfg.reboot_en;
    cfg_rdata[FAST_BIT]      = cfg.fast_scale;
    cfg_rdata[IRQ_LSB +: 2]  = cfg.irq_type;
    lck_rdata = '0;
    lck_rdata[FREE_BIT] = lck.free_run;
    lck_rdata[EN_BIT]   = lck.enable;
    lck_rdata[LOCK_BIT] = lck.locked;
  end

endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_regs_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int PRE_W  = 20,
  parameter int CFG_W  = 16,
  parameter int LCK_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mm_wr,
  input  logic              mm_rd,
  input  logic [ADDR_W-1:0] mm_addr,
  input  logic [1:0]        mm_size,
  input  logic [DATA_W-1:0] mm_wdata,
  output logic [DATA_W-1:0] mm_rdata,
  input  logic              cfg_wr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic              lck_wr,
  input  logic [LCK_W-1:0]  lck_wdata,
  output logic [LCK_W-1:0]  lck_rdata,
  input  logic              prev_rst_set,
  output logic              wd_enable,
  output logic              wd_free_run,
  output logic              wd_locked,
  output logic              wd_fast_scale,
  output logic [1:0]        wd_irq_type,
  output logic              wd_reboot_en,
  output logic              wd_ping,
  output logic              wd_flag_clr,
  output logic [PRE_W-1:0]  preload1,
  output logic [PRE_W-1:0]  preload2
);

  localparam logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(12);

  acc_size_t         size;
  logic [DATA_W-1:0] val;
  logic              accept;
  unlock_t           ul_state;
  cfg_t              cfg;
  lck_t              lck;

  assign size = acc_size_t'(mm_size);

  always_comb begin
    case (size)
      SZ_BYTE: val = {{(DATA_W-8){1'b0}},  mm_wdata[7:0]};
      SZ_HALF: val = {{(DATA_W-16){1'b0}}, mm_wdata[15:0]};
      default: val = mm_wdata;
    endcase
  end

  wdog_unlock_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_OFS(CTRL_OFS)
  ) u_unlock (
    .clk(clk), .rst(rst), .wr(mm_wr), .addr(mm_addr), .val(val),
    .size(size), .accept(accept), .state(ul_state)
  );

  wdog_mm_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRE_W(PRE_W), .CTRL_OFS(CTRL_OFS)
  ) u_mm (
    .clk(clk), .rst(rst), .accept(accept), .rd(mm_rd), .addr(mm_addr),
    .val(val), .size(size), .flag_set(prev_rst_set),
    .pre1(preload1), .pre2(preload2), .ping(wd_ping),
    .flag_clr(wd_flag_clr), .rdata(mm_rdata)
  );

  wdog_ctl_regs #(
    .CFG_W(CFG_W), .LCK_W(LCK_W)
  ) u_ctl (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .lck_wr(lck_wr), .lck_wdata(lck_wdata), .cfg(cfg), .lck(lck),
    .cfg_rdata(cfg_rdata), .lck_rdata(lck_rdata)
  );

  assign wd_enable     = lck.enable;
  assign wd_free_run   = lck.free_run;
  assign wd_locked     = lck.locked;
  assign wd_fast_scale = cfg.fast_scale;
  assign wd_irq_type   = cfg.irq_type;
  assign wd_reboot_en  = cfg.reboot_en;

endmodule

// File: rtl/wdog_regs_chk.sv
module wdog_regs_chk (
  input logic        clk,
  input logic        rst,
  input logic        mm_wr,
  input logic        mm_rd,
  input logic [3:0]  mm_addr,
  input logic [1:0]  mm_size,
  input logic [31:0] mm_wdata,
  input logic [31:0] mm_rdata,
  input logic        wd_enable,
  input logic        wd_free_run,
  input logic        wd_locked,
  input logic        wd_fast_scale,
  input logic [1:0]  wd_irq_type,
  input logic        wd_reboot_en,
  input logic        wd_ping,
  input logic        wd_flag_clr,
  input logic [19:0] preload1
);

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (wd_reboot_en && !wd_enable && !wd_locked && !wd_free_run
                    && !wd_fast_scale && wd_irq_type == 2'd0));

  // R6
  ping_src_chk: assert property (@(posedge clk) disable iff (rst)
    wd_ping |-> $past(mm_wr && mm_size == 2'd1 && mm_addr == 4'hC && mm_wdata[8]));

  // R3
  single_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (wd_ping || wd_flag_clr) |=> (!wd_ping && !wd_flag_clr));

  // R5
  pre1_src_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(preload1) |-> $past(mm_wr && mm_size == 2'd2 && mm_addr == 4'h0));

  // R9
  rdata_src_chk: assert property (@(posedge clk) disable iff (rst)
    (mm_rdata != 32'd0) |-> ($past(mm_rd && mm_size == 2'd1 && mm_addr == 4'hC)
                             && (mm_rdata == 32'h1200)));

  // R11
  lock_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    wd_locked |=> (wd_locked && $stable(wd_enable) && $stable(wd_free_run)));

endmodule

bind wdog_regs wdog_regs_chk u_chk (
  .clk(clk), .rst(rst), .mm_wr(mm_wr), .mm_rd(mm_rd), .mm_addr(mm_addr),
  .mm_size(mm_size), .mm_wdata(mm_wdata), .mm_rdata(mm_rdata),
  .wd_enable(wd_enable), .wd_free_run(wd_free_run), .wd_locked(wd_locked),
  .wd_fast_scale(wd_fast_scale), .wd_irq_type(wd_irq_type),
  .wd_reboot_en(wd_reboot_en), .wd_ping(wd_ping), .wd_flag_clr(wd_flag_clr),
  .preload1(preload1)
);

// File: tb/wdog_regs_tb.sv
`timescale 1ns/1ps
module wdog_regs_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mm_wr = 0, mm_rd = 0, cfg_wr = 0, lck_wr = 0, prev_rst_set = 0;
  logic [3:0]  mm_addr = 0;
  logic [1:0]  mm_size = 0;
  logic [31:0] mm_wdata = 0;
  logic [15:0] cfg_wdata = 0;
  logic [7:0]  lck_wdata = 0;
  logic [31:0] mm_rdata;
  logic [15:0] cfg_rdata;
  logic [7:0]  lck_rdata;
  logic wd_enable, wd_free_run, wd_locked, wd_fast_scale, wd_reboot_en;
  logic wd_ping, wd_flag_clr;
  logic [1:0]  wd_irq_type;
  logic [19:0] preload1, preload2;

  always #2.5 clk = ~clk;

  wdog_regs u_dut (.*);

  int n_chk = 0, n_fail = 0;
  int m_st = 0;
  logic [19:0] m_p1 = 20'hFFFFF, m_p2 = 20'hFFFFF;
  bit m_flag = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sz_mask(logic [31:0] d, logic [1:0] s);
    if (s == 2'd0) return d & 32'hFF;
    if (s == 2'd1) return d & 32'hFFFF;
    return d;
  endfunction

  // Model of R2..R8 for one write; returns {clr, ping}
  function automatic logic [1:0] model_wr(logic [3:0] a, logic [31:0] d,
                                          logic [1:0] s, bit fset);
    logic [31:0] v = sz_mask(d, s);
    logic p = 0, c = 0;
    if (a == 4'hC && v == 32'h80) m_st = 1;
    else if (a == 4'hC && v == 32'h86 && m_st == 1) m_st = 2;
    else if (m_st == 2 && (s == 2'd1 || s == 2'd2)) begin
      if (s == 2'd2 && a == 4'h0) m_p1 = v[19:0];
      if (s == 2'd2 && a == 4'h4) m_p2 = v[19:0];
      if (s == 2'd1 && a == 4'hC) begin
        p = v[8];
        c = v[9] | v[12];
      end
      m_st = 0;
    end
    if (fset) m_flag = 1;
    else if (c) m_flag = 0;
    return {c, p};
  endfunction

  task automatic wr(logic [3:0] a, logic [31:0] d, logic [1:0] s, bit fset = 0);
    logic [1:0] e;
    e = model_wr(a, d, s, fset);
    @(negedge clk);
    mm_wr = 1; mm_addr = a; mm_wdata = d; mm_size = s; prev_rst_set = fset;
    @(negedge clk);
    mm_wr = 0; prev_rst_set = 0;
    chk("R6 ping", {31'd0, wd_ping}, {31'd0, e[0]});
    chk("R7 flag_clr", {31'd0, wd_flag_clr}, {31'd0, e[1]});
    chk("R5/R3 preload1", {12'd0, preload1}, {12'd0, m_p1});
    chk("R5/R3 preload2", {12'd0, preload2}, {12'd0, m_p2});
  endtask

  task automatic rd(logic [3:0] a, logic [1:0] s);
    logic [31:0] e;
    e = (a == 4'hC && s == 2'd1 && m_flag) ? 32'h1200 : 32'h0;
    @(negedge clk);
    mm_rd = 1; mm_addr = a; mm_size = s;
    @(negedge clk);
    mm_rd = 0;
    chk("R9 rdata", mm_rdata, e);
  endtask

  task automatic set_flag();
    m_flag = 1;
    @(negedge clk); prev_rst_set = 1;
    @(negedge clk); prev_rst_set = 0;
  endtask

  task automatic arm();
    wr(4'hC, 32'h80, 2'd1);
    wr(4'hC, 32'h86, 2'd1);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 cfg_rdata", {16'd0, cfg_rdata}, 32'h0);
    chk("R1 lck_rdata", {24'd0, lck_rdata}, 32'h0);
    chk("R1 reboot_en", {31'd0, wd_reboot_en}, 32'h1);
    chk("R1 preload1", {12'd0, preload1}, 32'hFFFFF);
    chk("R1 preload2", {12'd0, preload2}, 32'hFFFFF);
    rd(4'hC, 2'd1);
    // R3 unarmed write ignored
    wr(4'h0, 32'h12345, 2'd2);
    // R5 armed write, masked
    arm(); wr(4'h0, 32'hABCDE123, 2'd2);
    chk("R5 preload1 value", {12'd0, preload1}, 32'hDE123);
    wr(4'h4, 32'h55555, 2'd2);                       // R3 guard closed
    // R3 unrelated write consumes the armed state
    arm(); wr(4'h8, 32'h0, 2'd2); wr(4'h4, 32'h77777, 2'd2);
    // R4 byte writes do not consume; R2 byte keys work
    wr(4'hC, 32'h80, 2'd0); wr(4'hC, 32'h86, 2'd0);
    wr(4'h0, 32'h55, 2'd0); wr(4'h0, 32'hFF, 2'd3);
    wr(4'h4, 32'h12345, 2'd2);
    chk("R4 preload2 after bytes", {12'd0, preload2}, 32'h12345);
    // R2 0x86 alone does not arm
    wr(4'hC, 32'h86, 2'd1); wr(4'h0, 32'h1, 2'd2);
    // R2 non-key write in first step keeps it; re-key while armed
    wr(4'hC, 32'h80, 2'd2); wr(4'h4, 32'h9, 2'd2); wr(4'hC, 32'h86, 2'd2);
    wr(4'hC, 32'h80, 2'd1); wr(4'hC, 32'h86, 2'd1);
    wr(4'h0, 32'hCAFE0, 2'd2);
    chk("R2 preload1 after rekey", {12'd0, preload1}, 32'hCAFE0);
    // R6 ping
    arm(); wr(4'hC, 32'h100, 2'd1);
    @(negedge clk); chk("R6 ping one cycle", {31'd0, wd_ping}, 32'h0);
    // R8/R9 flag and reads
    set_flag();
    rd(4'hC, 2'd1); rd(4'hC, 2'd2); rd(4'h8, 2'd1); rd(4'hC, 2'd0);
    // R7 clear via bit 12, then via bit 9
    arm(); wr(4'hC, 32'h1000, 2'd1); rd(4'hC, 2'd1);
    set_flag(); arm(); wr(4'hC, 32'h0300, 2'd1); rd(4'hC, 2'd1);
    // R8 set wins over a simultaneous clear
    arm(); wr(4'hC, 32'h0200, 2'd1, 1'b1); rd(4'hC, 2'd1);
    chk("R8 set wins", {31'd0, m_flag}, 32'h1);
    // R10 configuration
    @(negedge clk); cfg_wr = 1; cfg_wdata = 16'h0027;
    @(negedge clk); cfg_wr = 0;
    chk("R10 reboot_en", {31'd0, wd_reboot_en}, 32'h0);
    chk("R10 fast", {31'd0, wd_fast_scale}, 32'h1);
    chk("R10 irq", {30'd0, wd_irq_type}, 32'h3);
    chk("R10 readback", {16'd0, cfg_rdata}, 32'h0027);
    // R11 lock register
    @(negedge clk); lck_wr = 1; lck_wdata = 8'h06;
    @(negedge clk); lck_wr = 0;
    chk("R11 en/free", {29'd0, wd_free_run, wd_enable, wd_locked}, 32'h6);
    @(negedge clk); lck_wr = 1; lck_wdata = 8'h03;
    @(negedge clk); lck_wr = 0;
    chk("R11 lock set", {24'd0, lck_rdata}, 32'h3);
    @(negedge clk); lck_wr = 1; lck_wdata = 8'h04;
    @(negedge clk); lck_wr = 0;
    chk("R11 frozen", {24'd0, lck_rdata}, 32'h3);
    chk("R11 frozen enable", {31'd0, wd_enable}, 32'h1);
    @(negedge clk); cfg_wr = 1; cfg_wdata = 16'h0001;
    @(negedge clk); cfg_wr = 0;
    chk("R10 cfg after lock", {16'd0, cfg_rdata}, 32'h0001);
    chk("R10 reboot_en back", {31'd0, wd_reboot_en}, 32'h1);
    // random phase
    for (int i = 0; i < 600; i++) begin
      int k = $urandom % 10;
      logic [3:0] a; logic [31:0] d; logic [1:0] s;
      case ($urandom % 5)
        0: a = 4'h0; 1: a = 4'h4; 2, 3: a = 4'hC; default: a = 4'($urandom);
      endcase
      case ($urandom % 7)
        0, 1: d = 32'h80; 2: d = 32'h86; 3: d = 32'h100;
        4: d = 32'h1200; 5: d = 32'h300 | ($urandom & 32'hFFFF0000);
        default: d = $urandom;
      endcase
      s = 2'($urandom);
      if (k == 0) set_flag();
      else if (k == 1) rd(a, 2'($urandom));
      else wr(a, d, s, ($urandom % 16) == 0);
    end
    rd(4'hC, 2'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule